// File: doc/BRIEF.md
# Half-Bridge Supply and Thermal Output Gate

This block sits between the command register of a twelve-switch half-bridge driver and its gate drivers. It forms the final enable for each switch. A switch is enabled only when all of these hold: the command bit asks for it, the overcurrent or underload logic has not latched it off, no supply lockout is active, no thermal shutdown is active, and the device is awake. Supply and thermal faults hold the switches off only while the fault lasts. The command pattern is never altered, so the switches return to their programmed states on their own once the fault clears.

The block also holds two sticky status flags. One records a supply failure, which is an undervoltage or overvoltage on either rail. The other records a thermal warning from any of the six bridge sensors. Both flags stay set after the condition goes away. They clear only on a status-clear pulse, which is normally raised by a valid serial frame that carries the reset bit. While the device is asleep, every switch is off and both flags are held clear. The registered drive enables are also the values reported back as output state.

Top module: `hb_supply_gate`

## Requirements
- R1: An undervoltage flag on either rail turns all twelve drive enables off on the next clock and sets the supply-fail flag.
- R2: An overvoltage flag on either rail sets the supply-fail flag. When the overvoltage-lock input is 1, it also turns all drive enables off on the next clock.
- R3: When the overvoltage-lock input is 0, an overvoltage leaves the drive enables following the command. The supply-fail flag is still set.
- R4: After a supply fault clears, the drive enables return to the commanded pattern on the next clock, with no new command needed. The supply-fail flag stays set.
- R5: A shutdown flag from any one of the six thermal sensors turns all drive enables off on the next clock. When the flag clears, the previous selection returns unchanged.
- R6: A warning flag from any thermal sensor sets the thermal-warning flag and leaves the drive enables unchanged. The flag stays set after the warning goes away.
- R7: While the enable input is 0, all drive enables and both status flags are 0 from the next clock on, whatever the fault and command inputs are.
- R8: A status-clear pulse clears the supply-fail and thermal-warning flags on the next clock. If a flag's condition is present in the same cycle, that flag stays set, because set takes priority over clear.
- R9: With no fault and the enable input at 1, drive enable bit i equals command bit i AND NOT latched-off bit i. Bit 2k is the low-side switch and bit 2k+1 is the high-side switch of bridge k.
- R10: The synchronous active-high reset drives all drive enables and both flags to 0.
- R11: Every output is registered. A change on any input is seen at the outputs exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| en | input | 1 | Device awake; 0 selects sleep |
| cmd_sw | input | 12 | Commanded switch states |
| latch_off | input | 12 | Switches latched off by the current-fault logic |
| rail_uv | input | 2 | Undervoltage flag per supply rail |
| rail_ov | input | 2 | Overvoltage flag per supply rail |
| ovlo_en | input | 1 | Overvoltage-lock control: 1 = overvoltage turns outputs off |
| therm_warn | input | 6 | Thermal warning flag per bridge |
| therm_shut | input | 6 | Thermal shutdown flag per bridge |
| stat_clr | input | 1 | Status-clear pulse |
| drv_en | output | 12 | Final registered drive enables, also reported as output state |
| psf_flag | output | 1 | Sticky supply-fail flag |
| tw_flag | output | 1 | Sticky thermal-warning flag |

## Verification
The bench targets recovery after each fault: a design that cleared the command on a fault would leave the switches dark after recovery. It sends a clear in the same cycle as a live fault; a design that gave clear the priority would drop a flag whose fault is still present. It also drives overvoltage with the lock both on and off, which catches a design that gates on every overvoltage or ignores the lock setting. Finally, it puts faults on the outer rail and the outer sensor indexes and holds them during sleep, so a reduction that misses one index, or a flag that keeps its value while asleep, shows up as a mismatch.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
  // Summary of the supply monitor for one cycle.
  typedef struct packed {
    logic lockout;   // outputs must be held off
    logic fail_set;  // supply-fail flag must be set
  } rail_stat_t;

  // Summary of the thermal sensors for one cycle.
  typedef struct packed {
    logic shut_any;
    logic warn_any;
  } therm_stat_t;
endpackage

// File: rtl/hbg_rail_mon.sv
`timescale 1ns/1ps
module hbg_rail_mon #(
  parameter int N_RAIL = 2
) (
  input  logic [N_RAIL-1:0] rail_uv,
  input  logic [N_RAIL-1:0] rail_ov,
  input  logic              ovlo_en,
  output hbg_pkg::rail_stat_t stat
);
  logic uv_any, ov_any;

  always_comb begin
    uv_any = |rail_uv;
    ov_any = |rail_ov;
    stat.fail_set = uv_any | ov_any;
    // Undervoltage always locks out; overvoltage only when lock is chosen.
    stat.lockout  = uv_any | (ov_any & ovlo_en);
  end
endmodule

// File: rtl/hbg_therm_mon.sv
`timescale 1ns/1ps
module hbg_therm_mon #(
  parameter int N_BRIDGE = 6
) (
  input  logic [N_BRIDGE-1:0] therm_warn,
  input  logic [N_BRIDGE-1:0] therm_shut,
  output hbg_pkg::therm_stat_t stat
);
  always_comb begin
    stat.shut_any = |therm_shut;
    stat.warn_any = |therm_warn;
  end
endmodule

// File: rtl/hbg_sticky.sv
`timescale 1ns/1ps
module hbg_sticky (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // Set has priority over clear so a persisting fault re-arms the flag.
  always_ff @(posedge clk) begin
    if (rst || !en)  q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end
endmodule

// File: rtl/hbg_gate_cell.sv
`timescale 1ns/1ps
module hbg_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cmd,
  input  logic kill,
  input  logic block,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= en & cmd & ~kill & ~block;
  end
endmodule

// File: rtl/hb_supply_gate.sv
`timescale 1ns/1ps
module hb_supply_gate #(
  parameter int N_BRIDGE = 6,
  parameter int N_RAIL   = 2,
  localparam int N_SW    = 2 * N_BRIDGE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [N_SW-1:0]     cmd_sw,
  input  logic [N_SW-1:0]     latch_off,
  input  logic [N_RAIL-1:0]   rail_uv,
  input  logic [N_RAIL-1:0]   rail_ov,
  input  logic                ovlo_en,
  input  logic [N_BRIDGE-1:0] therm_warn,
  input  logic [N_BRIDGE-1:0] therm_shut,
  input  logic                stat_clr,
  output logic [N_SW-1:0]     drv_en,
  output logic                psf_flag,
  output logic                tw_flag
);
  hbg_pkg::rail_stat_t  rail_s;
  hbg_pkg::therm_stat_t therm_s;
  logic                 global_block;

  hbg_rail_mon #(.N_RAIL(N_RAIL)) u_rail (
    .rail_uv (rail_uv),
    .rail_ov (rail_ov),
    .ovlo_en (ovlo_en),
    .stat    (rail_s)
  );

  hbg_therm_mon #(.N_BRIDGE(N_BRIDGE)) u_therm (
    .therm_warn (therm_warn),
    .therm_shut (therm_shut),
    .stat       (therm_s)
  );

  // Faults that hold every switch off without touching the command.
  assign global_block = rail_s.lockout | therm_s.shut_any;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    hbg_gate_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .cmd   (cmd_sw[i]),
      .kill  (latch_off[i]),
      .block (global_block),
      .q     (drv_en[i])
    );
  end

  hbg_sticky u_psf (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .set_i (rail_s.fail_set),
    .clr_i (stat_clr),
    .q     (psf_flag)
  );

  hbg_sticky u_tw (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .set_i (therm_s.warn_any),
    .clr_i (stat_clr),
    .q     (tw_flag)
  );
endmodule

// File: rtl/hb_supply_gate_chk.sv
`timescale 1ns/1ps
module hb_supply_gate_chk #(
  parameter int N_BRIDGE = 6,
  parameter int N_RAIL   = 2,
  localparam int N_SW    = 2 * N_BRIDGE
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic [N_SW-1:0]     cmd_sw,
  input logic [N_SW-1:0]     latch_off,
  input logic [N_RAIL-1:0]   rail_uv,
  input logic [N_RAIL-1:0]   rail_ov,
  input logic                ovlo_en,
  input logic [N_BRIDGE-1:0] therm_warn,
  input logic [N_BRIDGE-1:0] therm_shut,
  input logic                stat_clr,
  input logic [N_SW-1:0]     drv_en,
  input logic                psf_flag,
  input logic                tw_flag
);
  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (|rail_uv) |=> (drv_en == '0)); // R1
  AST_UV_SETS_PSF: assert property (@(posedge clk) disable iff (rst)
    (en && (|rail_uv)) |=> psf_flag); // R1
  AST_OV_LOCK_OFF: assert property (@(posedge clk) disable iff (rst)
    ((|rail_ov) && ovlo_en) |=> (drv_en == '0)); // R2
  AST_OV_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (en && (|rail_ov) && !ovlo_en && !(|rail_uv) && !(|therm_shut))
      |=> (drv_en == $past(cmd_sw & ~latch_off))); // R3
  AST_TSD_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (|therm_shut) |=> (drv_en == '0)); // R5
  AST_TW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tw_flag && en && !stat_clr) |=> tw_flag); // R6
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((drv_en == '0) && !psf_flag && !tw_flag)); // R7
  AST_CLR_PSF: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !(|rail_uv) && !(|rail_ov)) |=> !psf_flag); // R8
  AST_NO_STRAY_ON: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drv_en & ~$past(cmd_sw & ~latch_off)) == '0)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ((drv_en == '0) && !psf_flag && !tw_flag)); // R10
endmodule

bind hb_supply_gate hb_supply_gate_chk #(.N_BRIDGE(N_BRIDGE), .N_RAIL(N_RAIL)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cmd_sw(cmd_sw), .latch_off(latch_off),
  .rail_uv(rail_uv), .rail_ov(rail_ov), .ovlo_en(ovlo_en),
  .therm_warn(therm_warn), .therm_shut(therm_shut), .stat_clr(stat_clr),
  .drv_en(drv_en), .psf_flag(psf_flag), .tw_flag(tw_flag)
);

// File: tb/sim_hb_supply_gate.sv
`timescale 1ns/1ps
module sim_hb_supply_gate;
  localparam int NB = 6;
  localparam int NR = 2;
  localparam int NS = 2 * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [NS-1:0] cmd_sw = '0;
  logic [NS-1:0] latch_off = '0;
  logic [NR-1:0] rail_uv = '0;
  logic [NR-1:0] rail_ov = '0;
  logic          ovlo_en = 1'b0;
  logic [NB-1:0] therm_warn = '0;
  logic [NB-1:0] therm_shut = '0;
  logic          stat_clr = 1'b0;
  logic [NS-1:0] drv_en;
  logic          psf_flag, tw_flag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [NS-1:0] m_drv = '0;
  logic          m_psf = 1'b0;
  logic          m_tw  = 1'b0;

  always #2 clk = ~clk;

  hb_supply_gate #(.N_BRIDGE(NB), .N_RAIL(NR)) u0 (
    .clk(clk), .rst(rst), .en(en), .cmd_sw(cmd_sw), .latch_off(latch_off),
    .rail_uv(rail_uv), .rail_ov(rail_ov), .ovlo_en(ovlo_en),
    .therm_warn(therm_warn), .therm_shut(therm_shut), .stat_clr(stat_clr),
    .drv_en(drv_en), .psf_flag(psf_flag), .tw_flag(tw_flag)
  );

  // Behavioural model of one clock edge, from the requirements.
  task automatic model_edge();
    bit any_uv, any_ov, any_shut, any_warn, off_all;
    any_uv = 0; any_ov = 0; any_shut = 0; any_warn = 0;
    for (int r = 0; r < NR; r++) begin
      if (rail_uv[r]) any_uv = 1;
      if (rail_ov[r]) any_ov = 1;
    end
    for (int b = 0; b < NB; b++) begin
      if (therm_shut[b]) any_shut = 1;
      if (therm_warn[b]) any_warn = 1;
    end
    off_all = any_uv || (any_ov && ovlo_en) || any_shut;
    if (rst) begin
      m_drv = '0; m_psf = 0; m_tw = 0;
    end else if (!en) begin
      m_drv = '0; m_psf = 0; m_tw = 0;
    end else begin
      for (int i = 0; i < NS; i++)
        m_drv[i] = cmd_sw[i] && !latch_off[i] && !off_all;
      if (any_uv || any_ov) m_psf = 1;
      else if (stat_clr)    m_psf = 0;
      if (any_warn)         m_tw = 1;
      else if (stat_clr)    m_tw = 0;
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    tests++;
    if (drv_en !== m_drv || psf_flag !== m_psf || tw_flag !== m_tw) begin
      fails++;
      $display("FAIL %s: drv=%h psf=%b tw=%b expected drv=%h psf=%b tw=%b",
               req, drv_en, psf_flag, tw_flag, m_drv, m_psf, m_tw);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    // R10: reset state
    cmd_sw = 12'hFFF; en = 1'b1;
    step("R10"); step("R10");
    rst = 1'b0; cmd_sw = 12'hA5C;
    // R11: one-clock latency, R9: plain gating
    step("R11"); step("R9");
    latch_off = 12'h00C; step("R9");
    latch_off = 12'h000; cmd_sw = 12'h3F0; step("R11");

    // R1 on rail 0, then R4 recovery
    rail_uv = 2'b01; step("R1"); step("R1");
    rail_uv = 2'b00; step("R4"); step("R4");
    // R1 on rail 1
    rail_uv = 2'b10; step("R1");
    rail_uv = 2'b00; step("R4");
    stat_clr = 1'b1; step("R8");
    stat_clr = 1'b0; step("R8");

    // R2 overvoltage with lock on
    ovlo_en = 1'b1; rail_ov = 2'b10; step("R2"); step("R2");
    // R3 lock off while overvoltage stays
    ovlo_en = 1'b0; step("R3"); step("R3");
    // R8 clear in the same cycle as a live fault: stays set
    stat_clr = 1'b1; step("R8");
    rail_ov = 2'b00; step("R8");
    stat_clr = 1'b0; step("R8");

    // R5 thermal shutdown, outer sensors
    cmd_sw = 12'hC33;
    therm_shut = 6'b100000; step("R5"); step("R5");
    therm_shut = 6'b000001; step("R5");
    therm_shut = 6'b000000; step("R5");

    // R6 thermal warning, sticky
    therm_warn = 6'b100000; step("R6");
    therm_warn = 6'b000000; step("R6"); step("R6");
    stat_clr = 1'b1; therm_warn = 6'b000001; step("R8");
    therm_warn = 6'b000000; step("R8");
    stat_clr = 1'b0; step("R8");

    // R7 sleep with faults present
    therm_warn = 6'b000100; rail_uv = 2'b01; step("R7");
    en = 1'b0; step("R7"); step("R7");
    rail_uv = 2'b00; therm_warn = 6'b000000; step("R7");
    en = 1'b1; step("R7"); step("R7");

    // R10: reset again mid-run
    rail_ov = 2'b01; therm_warn = 6'b010000; step("R10");
    rst = 1'b1; step("R10");
    rst = 1'b0; rail_ov = 2'b00; therm_warn = 6'b000000; step("R10");

    // Mixed patterns over all inputs
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_sw     = lfsr[11:0] ^ {lfsr[3:0], lfsr[15:8]};
      latch_off  = (lfsr[15:14] == 2'b00) ? {lfsr[5:0], lfsr[11:6]} : '0;
      rail_uv    = (lfsr[9:7] == 3'b111) ? lfsr[1:0] : '0;
      rail_ov    = (lfsr[6:4] == 3'b101) ? lfsr[3:2] : '0;
      ovlo_en    = lfsr[13];
      therm_shut = (lfsr[12:10] == 3'b011) ? lfsr[5:0] : '0;
      therm_warn = (lfsr[3:1] == 3'b110) ? lfsr[11:6] : '0;
      stat_clr   = (lfsr[8:6] == 3'b010);
      en         = (lfsr[15:12] != 4'h0);
      step("R9");
    end
    finish_run();
  end
endmodule